// File: doc/BRIEF.md
# Hall-Sensor Commutation Decoder with Dead Time

This block turns the three single-ended Hall sensor signals of a three-phase brushless motor into gate enables for three half-bridge legs. Each leg is pulled to the supply (high-side switch on), pulled to ground (low-side switch on), or left floating (both off). One decode table covers motors with 60° and with 120° sensor spacing, so no mode pin is needed. Motors with 240° or 300° spacing are run by flipping the direction input, since their code sequences are the mirror of the 120° and 60° sequences.

All inputs pass through a two-flop synchroniser. A registered decode stage then picks the target state of each leg. Enable has the highest priority, brake comes next and the Hall decode comes last. A guard on each leg enforces a blanking interval every time a switch turns off. The two switches of a leg are never on together, and after a turn-off neither switch turns on again until the interval has passed.

Top module: `bldc_commutator`

## Requirements
- R1: Hall bits are hall_i[0]=H1, hall_i[1]=H2, hall_i[2]=H3. For a code written H1H2H3, with fwd_i high, enable high and brake_n_i high, the legs (1,2,3) settle as follows. 100: (high, float, low). 110: (float, high, low). 010: (low, high, float). 111: (low, high, float). 011: (low, float, high). 001: (float, low, high). 101: (high, low, float). 000: (high, low, float). High means hs_o[k]=1 and ls_o[k]=0, low means hs_o[k]=0 and ls_o[k]=1, and float means both are 0. Leg k uses bit k-1 of each output.
- R2: Each code used by only one sensor spacing gives the same drive as its counterpart in the other spacing: 010 equals 111, and 101 equals 000.
- R3: With fwd_i low, every leg that would be high in forward is low, every leg that would be low is high, and floating legs stay floating.
- R4: With enable high and brake_n_i low, all three high-side enables settle to 1 and all low-side enables to 0, whatever the Hall code.
- R5: With en_i low, all six gate enables are 0 no later than 4 clock edges after the change, even when brake_n_i is low.
- R6: No leg ever has hs_o and ls_o both at 1 in the same cycle.
- R7: Once a switch of a leg turns off, both switches of that leg stay off for at least DEAD_CYCLES cycles (DEAD_CYCLES+1 in this design) before either turns on. A leg never moves straight from one switch to the other.
- R8: While rst is high, all gate enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hall_i | input | 3 | Hall sensors, bit 0 = H1, bit 2 = H3 (asynchronous) |
| fwd_i | input | 1 | 1 = forward, 0 = reverse |
| brake_n_i | input | 1 | Active-low brake |
| en_i | input | 1 | Active-high enable |
| hs_o | output | 3 | High-side gate enable per leg |
| ls_o | output | 3 | Low-side gate enable per leg |

## Verification
The bench builds the block with DEAD_CYCLES=8 in place of the default 100. This makes each blanking interval short enough that all eight Hall codes can be swept in both directions, followed by the brake and enable overrides, within a few thousand cycles. Because the interval is short, the exact number of fully-off cycles on a direction reversal can be counted and compared with the bound. A monitor also watches every cycle of the run for a leg with both switches on.

// File: rtl/bldc_pkg.sv
package bldc_pkg;

    localparam int NUM_LEGS = 3;

    typedef enum logic [1:0] {
        LEG_FLOAT = 2'd0,
        LEG_HIGH  = 2'd1,
        LEG_LOW   = 2'd2
    } leg_state_e;

    // Mirror a leg drive for reverse rotation; a floating leg stays floating.
    function automatic leg_state_e mirror(input leg_state_e s);
        case (s)
            LEG_HIGH: mirror = LEG_LOW;
            LEG_LOW:  mirror = LEG_HIGH;
            default:  mirror = LEG_FLOAT;
        endcase
    endfunction

    // Target drive of one leg for a Hall code; h1,h2,h3 are sensor levels.
    function automatic leg_state_e leg_drive(input logic h1, input logic h2,
                                             input logic h3, input logic fwd,
                                             input int leg);
        leg_state_e a, b, c, r;
        case ({h1, h2, h3})
            3'b100: begin a = LEG_HIGH;  b = LEG_FLOAT; c = LEG_LOW;   end
            3'b110: begin a = LEG_FLOAT; b = LEG_HIGH;  c = LEG_LOW;   end
            3'b010,
            3'b111: begin a = LEG_LOW;   b = LEG_HIGH;  c = LEG_FLOAT; end
            3'b011: begin a = LEG_LOW;   b = LEG_FLOAT; c = LEG_HIGH;  end
            3'b001: begin a = LEG_FLOAT; b = LEG_LOW;   c = LEG_HIGH;  end
            default: begin a = LEG_HIGH; b = LEG_LOW;   c = LEG_FLOAT; end // 101, 000
        endcase
        case (leg)
            0:       r = a;
            1:       r = b;
            default: r = c;
        endcase
        leg_drive = fwd ? r : mirror(r);
    endfunction

endpackage

// File: rtl/bldc_sync.sv
module bldc_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/bldc_comm_decode.sv
module bldc_comm_decode
    import bldc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] hall_s,
    input  logic       fwd_s,
    input  logic       brake_n_s,
    input  logic       en_s,
    output leg_state_e tgt_o [NUM_LEGS]
);
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NUM_LEGS; k++) tgt_o[k] <= LEG_FLOAT;
        end else begin
            for (int k = 0; k < NUM_LEGS; k++) begin
                if (!en_s)           tgt_o[k] <= LEG_FLOAT;
                else if (!brake_n_s) tgt_o[k] <= LEG_HIGH;
                else tgt_o[k] <= leg_drive(hall_s[0], hall_s[1], hall_s[2], fwd_s, k);
            end
        end
    end

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_chk
        assert_enable_off_R5: assert property (@(posedge clk) disable iff (rst)
            !en_s |=> (tgt_o[g] == LEG_FLOAT));
        assert_brake_high_R4: assert property (@(posedge clk) disable iff (rst)
            (en_s && !brake_n_s) |=> (tgt_o[g] == LEG_HIGH));
    end
endmodule

// File: rtl/bldc_leg_guard.sv
module bldc_leg_guard
    import bldc_pkg::*;
#(
    parameter int DEAD_CYCLES = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  leg_state_e tgt_i,
    output logic       hs_o,
    output logic       ls_o
);
    localparam int CW = $clog2(DEAD_CYCLES + 1);

    leg_state_e    cur_q;
    logic [CW-1:0] wait_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= LEG_FLOAT;
            wait_q <= '0;
        end else if (cur_q != LEG_FLOAT) begin
            if (tgt_i != cur_q) begin
                cur_q  <= LEG_FLOAT;
                wait_q <= CW'(DEAD_CYCLES);
            end
        end else if (wait_q != '0) begin
            wait_q <= wait_q - CW'(1);
        end else if (tgt_i != LEG_FLOAT) begin
            cur_q <= tgt_i;
        end
    end

    assign hs_o = (cur_q == LEG_HIGH);
    assign ls_o = (cur_q == LEG_LOW);

    // Checker: length of the current fully-off run, saturating.
    logic [CW-1:0] off_run_q;
    always_ff @(posedge clk) begin
        if (rst)                              off_run_q <= CW'(DEAD_CYCLES);
        else if (hs_o || ls_o)                off_run_q <= '0;
        else if (off_run_q < CW'(DEAD_CYCLES)) off_run_q <= off_run_q + CW'(1);
    end

    assert_no_shoot_R6: assert property (@(posedge clk) disable iff (rst)
        !(hs_o && ls_o));
    assert_dead_gap_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_o || ls_o) |-> (off_run_q >= CW'(DEAD_CYCLES)));
    assert_no_swap_hi_R7: assert property (@(posedge clk) disable iff (rst)
        hs_o |=> !ls_o);
    assert_no_swap_lo_R7: assert property (@(posedge clk) disable iff (rst)
        ls_o |=> !hs_o);
endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
    import bldc_pkg::*;
#(
    parameter int DEAD_CYCLES = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] hall_i,
    input  logic       fwd_i,
    input  logic       brake_n_i,
    input  logic       en_i,
    output logic [2:0] hs_o,
    output logic [2:0] ls_o
);
    localparam int SYNC_W = 6;

    logic [SYNC_W-1:0] sync_q;
    leg_state_e        tgt [NUM_LEGS];

    bldc_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({en_i, brake_n_i, fwd_i, hall_i}),
        .q_o (sync_q)
    );

    bldc_comm_decode u_dec (
        .clk       (clk),
        .rst       (rst),
        .hall_s    (sync_q[2:0]),
        .fwd_s     (sync_q[3]),
        .brake_n_s (sync_q[4]),
        .en_s      (sync_q[5]),
        .tgt_o     (tgt)
    );

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        bldc_leg_guard #(.DEAD_CYCLES(DEAD_CYCLES)) u_guard (
            .clk   (clk),
            .rst   (rst),
            .tgt_i (tgt[g]),
            .hs_o  (hs_o[g]),
            .ls_o  (ls_o[g])
        );
    end

    assert_reset_off_R8: assert property (@(posedge clk)
        rst |=> (hs_o == 3'b000 && ls_o == 3'b000));
endmodule

// File: tb/sim_bldc_commutator.sv
module sim_bldc_commutator;
    localparam int DEAD   = 8;
    localparam int SETTLE = 2 * DEAD + 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] hall_i = 3'b000;
    logic       fwd_i = 1'b1, brake_n_i = 1'b1, en_i = 1'b0;
    logic [2:0] hs_o, ls_o;

    int checks = 0, fails = 0, shoot = 0, cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bldc_commutator #(.DEAD_CYCLES(DEAD)) u0 (
        .clk(clk), .rst(rst), .hall_i(hall_i), .fwd_i(fwd_i),
        .brake_n_i(brake_n_i), .en_i(en_i), .hs_o(hs_o), .ls_o(ls_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected forward drive as characters: code is {h1,h2,h3}.
    function automatic string fwd_row(input logic [2:0] c);
        case (c)
            3'b100: return "HZL";
            3'b110: return "ZHL";
            3'b010: return "LHZ";
            3'b111: return "LHZ";
            3'b011: return "LZH";
            3'b001: return "ZLH";
            default: return "HLZ";
        endcase
    endfunction

    // Returns {hs,ls} expected on one leg.
    function automatic logic [1:0] exp_leg(input logic [2:0] c, input int leg, input bit fwd);
        string row = fwd_row(c);
        byte ch = row[leg];
        if (!fwd) ch = (ch == "H") ? "L" : (ch == "L") ? "H" : "Z";
        return (ch == "H") ? 2'b10 : (ch == "L") ? 2'b01 : 2'b00;
    endfunction

    task automatic settle();
        repeat (SETTLE) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Shoot-through monitor (R6)
    always @(negedge clk) begin
        cyc++;
        if (!rst && ((hs_o & ls_o) != 3'b000)) shoot++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            chk(1'b0, "R6", "watchdog expired", cyc, 100000);
            summary();
        end
    end

    initial begin
        logic [1:0] e;
        int gap;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        chk(hs_o == 3'b000 && ls_o == 3'b000, "R8", "outputs in reset", {hs_o, ls_o}, 0);
        rst = 1'b0;
        en_i = 1'b1;

        // R1, R3: every code in both directions
        for (int d = 1; d >= 0; d--) begin
            for (int c = 0; c < 8; c++) begin
                logic [2:0] cc = 3'(c);
                fwd_i  = d[0];
                hall_i = {cc[0], cc[1], cc[2]};
                settle();
                for (int k = 0; k < 3; k++) begin
                    e = exp_leg(cc, k, d[0]);
                    chk({hs_o[k], ls_o[k]} == e, d ? "R1" : "R3", $sformatf("code %b leg %0d", cc, k + 1),
                        {hs_o[k], ls_o[k]}, e);
                end
            end
        end

        // R2: spacing-specific codes share drives
        begin
            logic [5:0] a, b;
            fwd_i = 1'b1;
            hall_i = 3'b010; settle(); a = {hs_o, ls_o};   // H1H2H3 = 010
            hall_i = 3'b111; settle(); b = {hs_o, ls_o};
            chk(a == b && a == {3'b010, 3'b001}, "R2", "010 vs 111", b, a);
            hall_i = 3'b101; settle(); a = {hs_o, ls_o};
            hall_i = 3'b000; settle(); b = {hs_o, ls_o};
            chk(a == b && a == {3'b001, 3'b010}, "R2", "101 vs 000", b, a);
        end

        // R7: reverse leg 1 from high to low and count fully-off cycles
        fwd_i = 1'b1; hall_i = 3'b001;                      // H1=1 -> code 100
        settle();
        chk(hs_o[0] == 1'b1, "R7", "leg1 high before reversal", hs_o[0], 1);
        fwd_i = 1'b0;
        gap = 0;
        while (hs_o[0]) @(negedge clk);
        while (!ls_o[0] && gap < 200) begin gap++; @(negedge clk); end
        chk(gap >= DEAD && gap <= DEAD + 2, "R7", "off cycles on leg1", gap, DEAD + 1);

        // R4: brake from two codes
        for (int c = 0; c < 2; c++) begin
            hall_i = c ? 3'b011 : 3'b100;
            brake_n_i = 1'b0;
            settle();
            chk(hs_o == 3'b111 && ls_o == 3'b000, "R4", "brake drive", {hs_o, ls_o}, 6'b111000);
            brake_n_i = 1'b1;
            settle();
        end

        // R5: enable low overrides brake within 4 edges
        brake_n_i = 1'b0;
        settle();
        en_i = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(hs_o == 3'b000 && ls_o == 3'b000, "R5", "disable over brake", {hs_o, ls_o}, 0);
        brake_n_i = 1'b1;
        settle();
        chk(hs_o == 3'b000 && ls_o == 3'b000, "R5", "disabled with hall drive", {hs_o, ls_o}, 0);

        // R6: no cycle with both switches on
        chk(shoot == 0, "R6", "shoot-through cycles", shoot, 0);
        done = 1'b1;
        summary();
    end
endmodule